// File: doc/BRIEF.md
# Neighbour-Window Strip Trigger

This block decides, for a row of digitized strip channels, which channels carry a hit and whether the whole row should start event capture. Each accepted row holds one sample and one stored baseline per channel. The block removes the baseline from each sample, flooring the result at zero. It then adds each channel to its immediate neighbours, using a window of three or five channels as selected by a control pin. A channel is flagged when that local sum is strictly greater than a programmed 10-bit level.

The flags, a one-cycle capture trigger and the index of the lowest flagged channel are registered. They appear one clock after the row is accepted. The row input is a valid/ready stream with no back-pressure. `in_ready` is low while reset is held and high at every cycle after it, so every cycle with `in_valid` high is an accepted row. The producer may present a new row on every cycle. The outputs carry no ready signal and must be taken on the cycle `out_valid` is high. The level, window select and baselines are plain control pins that are sampled together with the row.

Top module: `adj_sum_trigger`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `hit_flags`, `trigger`, `out_valid` and `first_hit` are all zero. `in_ready` is 0 during reset and 1 from the first clock edge after reset onward.
- R2: Each channel's corrected value is its sample minus its baseline when the sample is larger, and zero otherwise (no wrap-around).
- R3: With `win5`=0, channel i's sum is the corrected values of channels i-1, i and i+1.
- R4: With `win5`=1, channel i's sum is the corrected values of channels i-2 through i+2.
- R5: Positions outside channels 0..N_CH-1 add zero to a window.
- R6: Bit i of `hit_flags` is 1 only when channel i's sum is strictly greater than `thresh`. A sum equal to `thresh` gives 0.
- R7: Sums hold five full-scale corrected values (5*(2^SAMPLE_W-1)) without overflow.
- R8: One clock after an accepted row, `out_valid` is high for exactly one cycle. `trigger` is high in that same cycle if and only if at least one flag is set. Without a new row, `trigger` is low on the following cycle.
- R9: `first_hit` equals the lowest set bit index of `hit_flags`, and is 0 when no flag is set.
- R10: On cycles with no accepted row, `out_valid` and `trigger` are low on the next cycle, and `hit_flags` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row present on `in_samples` |
| in_ready | output | 1 | High when a row can be taken (always after reset) |
| in_samples | input | N_CH*SAMPLE_W | Channel samples, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| in_pedestals | input | N_CH*SAMPLE_W | Per-channel baselines, same packing |
| thresh | input | THR_W | Hit level, compared with strict greater-than |
| win5 | input | 1 | 0: three-channel window, 1: five-channel window |
| hit_flags | output | N_CH | Per-channel hit flags of the last accepted row |
| out_valid | output | 1 | One-cycle pulse: new result on the outputs |
| trigger | output | 1 | One-cycle capture pulse when any flag is set |
| first_hit | output | IDX_W | Lowest flagged channel index, 0 when none |

## Verification
A wrong baseline floor shows up at once as flags on channels far from any real signal. An edge-tap or window fault flips flags at the row ends or at distance two from a peak. All of these appear in the `hit_flags` of the result cycle that follows the offending row. A wrong result or trigger register shows up within one or two cycles of a row: as a trigger without flags, a trigger that lasts two cycles, a `first_hit` that does not match the flag pattern, or flags that change on idle cycles.

// File: rtl/adj_trig_pkg.sv
package adj_trig_pkg;
  typedef enum logic {WIN3 = 1'b0, WIN5 = 1'b1} win_mode_e;
  localparam int TAPS = 5;
endpackage

// File: rtl/adj_ped_sub.sv
module adj_ped_sub #(
  parameter int W = 10
) (
  input  logic [W-1:0] raw,
  input  logic [W-1:0] ped,
  output logic [W-1:0] corr
);
  always_comb begin
    if (raw > ped) corr = raw - ped;
    else           corr = '0;
  end

  // R2: floored result never exceeds the raw sample
  always_comb begin
    p_floor_r2: assert (corr <= raw);
  end
endmodule

// File: rtl/adj_window_sum.sv
module adj_window_sum
  import adj_trig_pkg::*;
#(
  parameter int N     = 8,
  parameter int W     = 10,
  parameter int SUM_W = W + 3
) (
  input  logic [N*W-1:0]     corr,
  input  win_mode_e          mode,
  output logic [N*SUM_W-1:0] sums
);
  localparam int HALF = TAPS / 2;

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [SUM_W-1:0] term [TAPS];
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam int IDX = c + k - HALF;
      if (IDX < 0 || IDX >= N) begin : g_edge
        assign term[k] = '0;
      end else if (k == 0 || k == TAPS - 1) begin : g_outer
        assign term[k] = (mode == WIN5) ? SUM_W'(corr[IDX*W +: W]) : '0;
      end else begin : g_inner
        assign term[k] = SUM_W'(corr[IDX*W +: W]);
      end
    end
    assign sums[c*SUM_W +: SUM_W] = term[0] + term[1] + term[2] + term[3] + term[4];
  end
endmodule

// File: rtl/adj_lowest_idx.sv
module adj_lowest_idx #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     flags,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags[i]) idx = IDX_W'(i);
    end
    any = |flags;
  end
endmodule

// File: rtl/adj_sum_trigger.sv
module adj_sum_trigger
  import adj_trig_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int SAMPLE_W = 10,
  parameter int THR_W    = 10,
  parameter int IDX_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [N_CH*SAMPLE_W-1:0] in_samples,
  input  logic [N_CH*SAMPLE_W-1:0] in_pedestals,
  input  logic [THR_W-1:0]         thresh,
  input  logic                     win5,
  output logic [N_CH-1:0]          hit_flags,
  output logic                     out_valid,
  output logic                     trigger,
  output logic [IDX_W-1:0]         first_hit
);
  localparam int SUM_W = SAMPLE_W + $clog2(TAPS);

  logic [N_CH*SAMPLE_W-1:0] corr;
  logic [N_CH*SUM_W-1:0]    sums;
  logic [N_CH-1:0]          hit_d;
  logic [IDX_W-1:0]         idx_d;
  logic                     any_d;
  logic                     accept;
  win_mode_e                mode;

  assign mode   = win5 ? WIN5 : WIN3;
  assign accept = in_valid && in_ready;

  for (genvar c = 0; c < N_CH; c++) begin : g_ped
    adj_ped_sub #(.W(SAMPLE_W)) u_sub (
      .raw  (in_samples[c*SAMPLE_W +: SAMPLE_W]),
      .ped  (in_pedestals[c*SAMPLE_W +: SAMPLE_W]),
      .corr (corr[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  adj_window_sum #(.N(N_CH), .W(SAMPLE_W), .SUM_W(SUM_W)) u_win (
    .corr (corr),
    .mode (mode),
    .sums (sums)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_cmp
    assign hit_d[c] = sums[c*SUM_W +: SUM_W] > SUM_W'(thresh);
  end

  adj_lowest_idx #(.N(N_CH), .IDX_W(IDX_W)) u_low (
    .flags (hit_d),
    .idx   (idx_d),
    .any   (any_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      hit_flags <= '0;
      first_hit <= '0;
      trigger   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      in_ready  <= 1'b1;
      out_valid <= accept;
      trigger   <= accept && any_d;
      if (accept) begin
        hit_flags <= hit_d;
        first_hit <= idx_d;
      end
    end
  end

  // R8: a trigger always comes with at least one flag
  p_trig_has_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> (|hit_flags && out_valid));
  // R8: result one cycle after each accepted row
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R8: trigger is a single-cycle pulse unless a fresh row arrived
  p_trig_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (!trigger || $past(accept)));
  // R10: idle cycles leave flags untouched and give no result
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(hit_flags) && !out_valid));
  // R9: reported index is the lowest flagged channel
  p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> (hit_flags[first_hit] &&
                 ((hit_flags & ((N_CH'(1) << first_hit) - N_CH'(1))) == '0)));
  // R9: no flags means index zero
  p_nohit_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !trigger) |-> (first_hit == '0 && hit_flags == '0));
endmodule

// File: tb/adj_sum_trigger_test.sv
module adj_sum_trigger_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 10;

  typedef struct packed {
    logic [2:0] pos;
    logic [9:0] amp;
    logic [9:0] nb;
    logic [9:0] ped;
    logic [9:0] thr;
    logic       w5;
    logic [7:0] exp_flags;
    logic [2:0] exp_first;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 10'd100, 10'd0,  10'd0, 10'd99,  1'b0, 8'b0001_1100, 3'd2}, // R3 peak spreads
    '{3'd3, 10'd100, 10'd0,  10'd0, 10'd100, 1'b0, 8'b0000_0000, 3'd0}, // R6 equal no hit
    '{3'd3, 10'd50,  10'd30, 10'd0, 10'd100, 1'b0, 8'b0000_1000, 3'd3}, // R3 neighbours add
    '{3'd3, 10'd50,  10'd30, 10'd0, 10'd100, 1'b1, 8'b0001_1100, 3'd2}, // R4 wider window
    '{3'd0, 10'd60,  10'd0,  10'd5, 10'd59,  1'b0, 8'b0000_0011, 3'd0}, // R5 low edge
    '{3'd7, 10'd60,  10'd0,  10'd5, 10'd59,  1'b1, 8'b1110_0000, 3'd5}  // R5 high edge
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N*W-1:0] in_samples;
  logic [N*W-1:0] in_pedestals;
  logic [9:0] thresh = '0;
  logic win5 = 1'b0;
  logic [N-1:0] hit_flags;
  logic out_valid;
  logic trigger;
  logic [2:0] first_hit;
  logic [W-1:0] samp [N];
  logic [W-1:0] peds [N];

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      in_samples[c*W +: W]   = samp[c];
      in_pedestals[c*W +: W] = peds[c];
    end
  end

  adj_sum_trigger uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .in_pedestals(in_pedestals), .thresh(thresh),
    .win5(win5), .hit_flags(hit_flags), .out_valid(out_valid),
    .trigger(trigger), .first_hit(first_hit)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one row accepted; outputs sampled on the negedge after the capturing edge
  task automatic strobe();
    @(negedge clk) in_valid = 1'b1;
    @(negedge clk) in_valid = 1'b0;
  endtask

  task automatic fill(input logic [W-1:0] s, input logic [W-1:0] p);
    for (int c = 0; c < N; c++) begin
      samp[c] = s;
      peds[c] = p;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    fill('0, '0);
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", 32'(in_ready), 0);
    chk("R1", "flags in reset", 32'(hit_flags), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready after reset", 32'(in_ready), 1);
    chk("R1", "trigger after reset", 32'(trigger), 0);
    chk("R1", "out_valid after reset", 32'(out_valid), 0);
    chk("R1", "first_hit after reset", 32'(first_hit), 0);

    for (int v = 0; v < NV; v++) begin
      fill(VECS[v].ped, VECS[v].ped);
      samp[VECS[v].pos] = VECS[v].amp + VECS[v].ped;
      if (VECS[v].pos > 0) samp[VECS[v].pos - 1] = VECS[v].nb + VECS[v].ped;
      if (VECS[v].pos < N - 1) samp[VECS[v].pos + 1] = VECS[v].nb + VECS[v].ped;
      thresh = VECS[v].thr;
      win5   = VECS[v].w5;
      strobe();
      chk("R3/R4/R5/R6", $sformatf("flags vec %0d", v), 32'(hit_flags), 32'(VECS[v].exp_flags));
      chk("R8", $sformatf("out_valid vec %0d", v), 32'(out_valid), 1);
      chk("R8", $sformatf("trigger vec %0d", v), 32'(trigger), 32'(VECS[v].exp_flags != 0));
      chk("R9", $sformatf("first_hit vec %0d", v), 32'(first_hit), 32'(VECS[v].exp_first));
      @(negedge clk);
      chk("R8", $sformatf("pulse ends vec %0d", v), 32'(trigger), 0);
      chk("R10", $sformatf("idle hold vec %0d", v), 32'(hit_flags), 32'(VECS[v].exp_flags));
    end

    // R2: samples below baseline floor to zero; only channel 3 carries 100
    fill(10'd0, 10'd500);
    samp[3] = 10'd600;
    thresh = 10'd99; win5 = 1'b0;
    strobe();
    chk("R2", "floored baseline flags", 32'(hit_flags), 32'h1C);
    chk("R2", "floored baseline first", 32'(first_hit), 2);

    // R7: full-scale row, five-channel window, no overflow
    fill(10'd1023, 10'd0);
    thresh = 10'd1023; win5 = 1'b1;
    strobe();
    chk("R7", "full scale flags", 32'(hit_flags), 32'hFF);
    chk("R7", "full scale trigger", 32'(trigger), 1);

    // R10: several idle cycles keep flags, no pulses
    fill(10'd0, 10'd0);
    repeat (3) begin
      @(negedge clk);
      chk("R10", "idle out_valid", 32'(out_valid), 0);
      chk("R10", "idle flags", 32'(hit_flags), 32'hFF);
    end

    // R8: back-to-back rows; second row has no hit
    @(negedge clk) in_valid = 1'b1;
    fill(10'd200, 10'd0); thresh = 10'd100; win5 = 1'b0;
    @(negedge clk);
    chk("R8", "b2b first trigger", 32'(trigger), 1);
    fill(10'd0, 10'd0);
    @(negedge clk) in_valid = 1'b0;
    chk("R8", "b2b second out_valid", 32'(out_valid), 1);
    chk("R8", "b2b second trigger", 32'(trigger), 0);
    chk("R9", "no hit index", 32'(first_hit), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule